// File: doc/BRIEF.md
# GPIO Bank Interrupt Cause Logic

This block turns the input pins of a GPIO bank (32 lines by default) into interrupt requests. Each line has an input inversion bit, a direction bit, an edge-enable bit and a level-enable bit. The synchronized pin value, inverted where the line's inversion bit is set, is the line's effective input. A level-enabled line requests an interrupt for as long as its effective input is 1. An edge-enabled line latches each 0-to-1 transition of its effective input into a sticky edge cause bit. Software clears that bit by writing 0 to it.

The enabled requests are ORed in groups of eight consecutive lines, which gives one interrupt output per group. A flat register port with byte offsets gives software access to the settings, the synchronized input value and the edge cause bits. Interrupt enables can only be set on lines configured as inputs. A write that tries to enable an output line is flagged for one cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the direction register reads all ones (every line an input). The inversion, edge-enable, level-enable and edge cause registers read 0, every group output is 0 and the configuration error output is 0.
- R2: Pins pass through two flops. The data-in register (offset 0x10) shows a pin change two cycles after the change and still shows the old value one cycle after it.
- R3: The effective input of a line is its synchronized pin XOR its inversion bit (offset 0x0C). A line whose level-enable bit (offset 0x1C) is set drives its group output high while its effective input is 1, and low while it is 0.
- R4: A 0-to-1 transition of a line's effective input sets that line's edge cause bit (offset 0x14). The bit stays set after the input returns to 0.
- R5: Writing the edge cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: When a new edge on a line and a clearing write to that line's cause bit fall on the same clock edge, the bit ends up set.
- R7: A set edge cause bit drives its group output only while the line's edge-enable bit (offset 0x18) is set.
- R8: Line i drives only group output i/8. Bit 0 of the group output carries lines 0 to 7 and bit 3 carries lines 24 to 31.
- R9: In the direction register (offset 0x04), 1 marks an input. A write to either enable register stores 0 in every bit whose line is an output. It raises the configuration error output for exactly the next cycle if it tried to set any such bit, and keeps that output low otherwise.
- R10: A line with neither enable bit set never drives a group output, whatever its edge cause bit and its effective input hold.
- R11: Reads are combinational from the address. The inversion register reads back what was written. Writes to the data-in register are ignored, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NLINES | Raw, asynchronous pin values |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data for reg_addr, combinational |
| cfg_err | output | 1 | One-cycle flag: an enable write tried to arm an output line |
| irq_grp | output | NLINES/8 | Registered interrupt output per group of eight lines |

## Verification
Each result has a fixed latency from its stimulus, counted in rising clock edges:
- data-in: 2 edges after a pin change.
- Level-driven group output: 3 edges after a pin change, or 1 edge after a write to an enable or inversion register.
- Edge cause bit: 3 edges after a pin change.
- Edge-driven group output: 4 edges after a pin change.
- Configuration error flag: 1 edge after the write.

The driver tags every expected item with the cycle count at which it is due. The monitor compares each item at the falling edge of exactly that cycle. For the data-in and edge-driven outputs, items are also queued one cycle early with the old value, which pins each latency from both sides. The same-edge clear and set case is placed by driving the write strobe in the cycle whose rising edge also latches the edge.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the GPIO bank interrupt logic.
// Assumes byte offsets on an 8-bit register address.
package gpio_irq_pkg;

    localparam int unsigned REG_ADDR_W = 8;

    // Register byte offsets; the two enable offsets are fixed by software.
    localparam logic [REG_ADDR_W-1:0] OFS_DIR    = 8'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_POL    = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_DIN    = 8'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_ECAUSE = 8'h14;
    localparam logic [REG_ADDR_W-1:0] OFS_EMASK  = 8'h18;
    localparam logic [REG_ADDR_W-1:0] OFS_LMASK  = 8'h1C;

    // One-hot write strobes decoded from the register port.
    typedef struct packed {
        logic dir;
        logic pol;
        logic ecause;
        logic emask;
        logic lmask;
    } wr_sel_t;

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 2 and that each bit is sampled independently.
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= d;
            end
        end else begin : g_next
            // Later flops pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge_cause.sv
`timescale 1ns/1ps
// Rising-edge detector and sticky edge cause register, one bit per line.
// Assumes eff is already synchronized. A write clears the bits written as 0,
// and a new edge on the same clock edge wins over the clear.
module gpio_irq_edge_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] eff,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] cause
);
    logic [W-1:0] eff_q;
    logic [W-1:0] cause_q;
    logic [W-1:0] edge_v;
    logic [W-1:0] clr_mask;

    // Previous effective input, kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q <= '0;
        else        eff_q <= eff;
    end

    // Rising edges and clear bits (write 0 clears).
    always_comb begin
        edge_v   = eff & ~eff_q;
        clr_mask = clr_we ? ~clr_data : '0;
    end

    // Sticky cause: clear first, then set from new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_mask) | edge_v;
    end

    assign cause = cause_q;

    AST_EDGE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_v) & ~cause_q) == '0)); // R6

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cause_q) & ~$past(clr_mask) & ~cause_q) == '0)); // R5
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
// Register file: direction, inversion, edge and level enables, read mux.
// Assumes one access per cycle and combinational reads. Enable bits for
// output lines are dropped on write, and the attempt is flagged for a cycle.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  we,
    input  logic [W-1:0]          wdata,
    input  logic [W-1:0]          din,
    input  logic [W-1:0]          cause,
    output logic [W-1:0]          rdata,
    output logic [W-1:0]          dir,
    output logic [W-1:0]          pol,
    output logic [W-1:0]          emask,
    output logic [W-1:0]          lmask,
    output logic                  ecause_we,
    output logic                  cfg_err
);
    wr_sel_t      sel;
    logic [W-1:0] dir_q, pol_q, emask_q, lmask_q;
    logic         err_q;
    logic         bad_arm;

    // Decode the write strobes and spot enables that target output lines.
    always_comb begin
        sel.dir    = we && (addr == OFS_DIR);
        sel.pol    = we && (addr == OFS_POL);
        sel.ecause = we && (addr == OFS_ECAUSE);
        sel.emask  = we && (addr == OFS_EMASK);
        sel.lmask  = we && (addr == OFS_LMASK);
        bad_arm    = (sel.emask || sel.lmask) && (|(wdata & ~dir_q));
    end

    // Setting registers; enables keep only the bits of input lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '1;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else begin
            if (sel.dir)   dir_q   <= wdata;
            if (sel.pol)   pol_q   <= wdata;
            if (sel.emask) emask_q <= wdata & dir_q;
            if (sel.lmask) lmask_q <= wdata & dir_q;
        end
    end

    // One-cycle configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_arm;
    end

    // Combinational read mux; unmapped offsets return 0.
    always_comb begin
        case (addr)
            OFS_DIR:    rdata = dir_q;
            OFS_POL:    rdata = pol_q;
            OFS_DIN:    rdata = din;
            OFS_ECAUSE: rdata = cause;
            OFS_EMASK:  rdata = emask_q;
            OFS_LMASK:  rdata = lmask_q;
            default:    rdata = '0;
        endcase
    end

    assign dir       = dir_q;
    assign pol       = pol_q;
    assign emask     = emask_q;
    assign lmask     = lmask_q;
    assign ecause_we = sel.ecause;
    assign cfg_err   = err_q;

    AST_EMASK_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sel.emask |=> ((emask_q & ~$past(dir_q)) == '0)); // R9

    AST_LMASK_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sel.lmask |=> ((lmask_q & ~$past(dir_q)) == '0)); // R9

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(we)); // R9
endmodule

// File: rtl/gpio_irq_group.sv
`timescale 1ns/1ps
// Gates the causes with the enables and ORs each group of GRP lines into
// one registered interrupt output. Assumes W is a multiple of GRP.
module gpio_irq_group #(
    parameter int W   = 32,
    parameter int GRP = 8,
    localparam int NG = W / GRP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  eff,
    input  logic [W-1:0]  cause,
    input  logic [W-1:0]  emask,
    input  logic [W-1:0]  lmask,
    output logic [NG-1:0] irq
);
    logic [W-1:0]  pend;
    logic [NG-1:0] irq_d;
    logic [NG-1:0] irq_q;

    // Per-line pending request: enabled edge cause or enabled level.
    always_comb pend = (cause & emask) | (eff & lmask);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        // OR of one group of lines.
        always_comb irq_d[g] = |pend[g*GRP +: GRP];
    end

    // Registered group outputs, so the interrupt lines are glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((emask | lmask) == '0) |=> (irq == '0)); // R10

    AST_NO_IRQ_WITHOUT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause == '0) && (eff == '0)) |=> (irq == '0)); // R7
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
// Top of the GPIO bank interrupt logic: synchronizer, inversion, edge cause
// register, register file and grouped interrupt outputs.
// Assumes NLINES is a multiple of 8 and at most the register data width.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int SYNC_STAGES = 2,
    parameter int GRP = 8,
    localparam int NGRP = NLINES / GRP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLINES-1:0]     pin_in,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_we,
    input  logic [NLINES-1:0]     reg_wdata,
    output logic [NLINES-1:0]     reg_rdata,
    output logic                  cfg_err,
    output logic [NGRP-1:0]       irq_grp
);
    logic [NLINES-1:0] din_sync;
    logic [NLINES-1:0] eff;
    logic [NLINES-1:0] dir, pol, emask, lmask, cause;
    logic              ecause_we;

    gpio_irq_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_sync)
    );

    // Shared inversion feeding both the level path and the edge path.
    always_comb eff = din_sync ^ pol;

    gpio_irq_edge_cause #(.W(NLINES)) u_cause (
        .clk(clk), .rst_n(rst_n), .eff(eff),
        .clr_we(ecause_we), .clr_data(reg_wdata), .cause(cause)
    );

    gpio_irq_regs #(.W(NLINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .din(din_sync), .cause(cause), .rdata(reg_rdata),
        .dir(dir), .pol(pol), .emask(emask), .lmask(lmask),
        .ecause_we(ecause_we), .cfg_err(cfg_err)
    );

    gpio_irq_group #(.W(NLINES), .GRP(GRP)) u_group (
        .clk(clk), .rst_n(rst_n), .eff(eff), .cause(cause),
        .emask(emask), .lmask(lmask), .irq(irq_grp)
    );

    AST_RESET_ALL_INPUTS: assert property (@(posedge clk)
        !rst_n |=> (dir == '1) && (cause == '0) && (irq_grp == '0)); // R1
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
    localparam logic [7:0] A_DIR = 8'h04, A_POL = 8'h0C, A_DIN = 8'h10;
    localparam logic [7:0] A_EC = 8'h14, A_EM = 8'h18, A_LM = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_err;
    logic [3:0]  irq_grp;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_err(cfg_err), .irq_grp(irq_grp)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every item that is due and compare it with the outputs.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            case (it.sel)
                0:       act = reg_rdata;
                1:       act = {28'b0, irq_grp};
                default: act = {31'b0, cfg_err};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h at cycle %0d",
                         it.tag, it.sel, act, it.exp, cyc);
            end
        end
    end

    task automatic push(int d, int s, logic [31:0] e, string t);
        item_t x;
        x.due = d; x.sel = s; x.exp = e; x.tag = t;
        sb.push_back(x);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string t);
        @(negedge clk);
        reg_addr = a;
        push(cyc, 0, e, t);
    endtask

    task automatic irq_chk(logic [3:0] e, string t);
        @(negedge clk);
        push(cyc, 1, {28'b0, e}, t);
    endtask

    task automatic err_chk(logic e, string t);
        push(cyc, 2, {31'b0, e}, t);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_pins(logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_DIR, 32'hFFFF_FFFF, "R1");
        rd(A_POL, 32'h0, "R1");
        rd(A_EM, 32'h0, "R1");
        rd(A_LM, 32'h0, "R1");
        rd(A_EC, 32'h0, "R1");
        irq_chk(4'h0, "R1");
        err_chk(1'b0, "R1");
        // R2 two-flop latency on data-in
        @(negedge clk);
        pin_in = 32'hA5A5_0F0F; reg_addr = A_DIN;
        push(cyc + 1, 0, 32'h0, "R2");
        push(cyc + 2, 0, 32'hA5A5_0F0F, "R2");
        tick(3);
        // R4 rising edges latched
        rd(A_EC, 32'hA5A5_0F0F, "R4");
        // R5 write-zero clear
        wr(A_EC, 32'hFFFF_0000);
        rd(A_EC, 32'hA5A5_0000, "R5");
        wr(A_EC, 32'h0);
        rd(A_EC, 32'h0, "R5");
        // R11 data-in write ignored, unmapped read
        wr(A_DIN, 32'h0);
        rd(A_DIN, 32'hA5A5_0F0F, "R11");
        rd(8'h00, 32'h0, "R11");
        // R3 level with inversion
        wr(A_LM, 32'h8);
        irq_chk(4'h1, "R3");
        wr(A_POL, 32'h8);
        rd(A_POL, 32'h8, "R11");
        irq_chk(4'h0, "R3");
        set_pins(32'hA5A5_0F07);
        tick(2);
        irq_chk(4'h1, "R3");
        rd(A_EC, 32'h8, "R4");
        wr(A_EC, 32'h0);
        wr(A_LM, 32'h0);
        wr(A_POL, 32'h0);
        irq_chk(4'h0, "R3");
        // R7 edge enable, R8 group 3
        wr(A_EM, 32'h0100_0000);
        set_pins(32'hA4A5_0F07);
        tick(4);
        set_pins(32'hA5A5_0F07);
        tick(2);
        irq_chk(4'h0, "R7");
        irq_chk(4'h8, "R7");
        set_pins(32'hA4A5_0F07);
        tick(4);
        irq_chk(4'h8, "R4");
        wr(A_EC, 32'hFEFF_FFFF);
        irq_chk(4'h0, "R5");
        // R6 edge and clear on the same clock edge
        set_pins(32'hA5A5_0F07);
        tick(1);
        @(negedge clk);
        reg_addr = A_EC; reg_wdata = 32'h0; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(A_EC, 32'h0100_0000, "R6");
        wr(A_EC, 32'h0);
        wr(A_EM, 32'h0);
        // R9 enables only on input lines
        wr(A_DIR, 32'hFFFF_FFFE);
        err_chk(1'b0, "R9");
        wr(A_EM, 32'h3);
        err_chk(1'b1, "R9");
        rd(A_EM, 32'h2, "R9");
        err_chk(1'b0, "R9");
        wr(A_LM, 32'h2);
        err_chk(1'b0, "R9");
        rd(A_LM, 32'h2, "R9");
        wr(A_LM, 32'h0);
        wr(A_EM, 32'h0);
        wr(A_DIR, 32'hFFFF_FFFF);
        rd(A_DIR, 32'hFFFF_FFFF, "R9");
        // R10 no enables, no interrupt
        set_pins(32'h0);
        tick(4);
        set_pins(32'hFFFF_FFFF);
        tick(4);
        irq_chk(4'h0, "R10");
        rd(A_EC, 32'hFFFF_FFFF, "R10");
        wr(A_EC, 32'h0);
        // R8 grouping
        set_pins(32'h0000_0200);
        wr(A_LM, 32'h0000_FF00);
        tick(2);
        irq_chk(4'h2, "R8");
        wr(A_LM, 32'hFFFF_FFFF);
        set_pins(32'h8000_0000);
        tick(2);
        irq_chk(4'h8, "R8");
        tick(6);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items never checked", sb.size());
        end
        finish_run();
    end
endmodule